// File: doc/BRIEF.md
# Write-Enable and Block-Protect Status Unit

This unit owns the status byte of a small serial EEPROM with a 512-byte array. It keeps the write-enable latch, the busy flag of the self-timed program cycle and a two-bit block-protect code. It also applies the active-low hardware write-protect pin. A serial front end shifts bits in and out and tells this unit three things: when an opcode byte is complete, when each later byte is complete, and when chip select rises. The unit decides at the rise of chip select whether the frame changes the latch or the protect code, or starts a program cycle.

Every cycle the unit returns the status byte, so the front end can shift it out at any time, including during a program cycle. It also returns a write-permitted flag for the address the front end currently targets. The protect code is nonvolatile in the device. Here it is an ordinary register that reset loads from a parameter.

Frame tracking is a small state machine. Its states are FR_IDLE (no command held), FR_WREN, FR_WRDI, FR_WRSR, FR_WRITE and FR_PASSIVE (read-type or unknown opcode). Three transitions exist. An opcode strobe enters the state the decoded opcode selects. A data-byte strobe keeps the state and records that a data byte followed. The rise of chip select returns to FR_IDLE and may issue a commit. The program-cycle state machine has two states, ST_READY and ST_BUSY. An accepted status or array write moves it from ST_READY to ST_BUSY. When its countdown expires it moves back to ST_READY.

Top module: `prot_status_unit`

## Requirements
- R1: The status byte holds busy in bit 0, the write-enable latch in bit 1 and the protect code in bits 3:2, with bits 7:4 always 0. After reset, busy and the latch are 0 and the code equals the parameter BP_INIT.
- R2: Opcode 0x06 sets the latch only when chip select rises on a byte boundary with no byte after the opcode. A following byte or a misaligned rise leaves the latch unchanged.
- R3: Opcode 0x04 clears the latch under the same frame rule as R2, whatever the protect code.
- R4: While wp_n is low, the latch is 0 without waiting for a clock edge, and opcode 0x06 has no effect.
- R5: Opcode 0x01, followed by at least one data byte and ended on a boundary, is accepted when the latch is 1, wp_n is 1 and the unit is not busy. On acceptance the code takes bits 3:2 of the last data byte, the latch clears and busy starts. Otherwise nothing changes. Bits 7:4 and 1:0 of the data byte never affect the status.
- R6: A write opcode (bits 7:4 = 0, bits 2:0 = 010, bit 3 free), followed by at least one data byte and ended on a boundary, is accepted when write_ok is 1 and the unit is not busy. On acceptance the latch clears and busy starts. Otherwise nothing changes.
- R7: The protect code guards these ranges: 00 none, 01 addresses 0x180 to 0x1FF, 10 addresses 0x100 to 0x1FF, 11 the whole array.
- R8: write_ok equals latch AND wp_n AND (addr outside the guarded range).
- R9: Busy stays 1 for exactly WR_CYCLES clock cycles after the accepting edge. wp_n going low does not shorten it.
- R10: While busy, the opcodes 0x06, 0x04, 0x01 and the write opcode change nothing, and the status byte still reads out with busy = 1.
- R11: Opcode 0x05 and the read opcode 0x03 never change the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Hardware write protect, active low, asynchronous on the latch |
| op_valid | input | 1 | Opcode byte complete (first byte of a frame) |
| op_code | input | 8 | Opcode byte, valid with op_valid |
| byte_stb | input | 1 | A byte after the opcode is complete |
| sr_wdata | input | 8 | Last byte shifted in, used by a status write |
| cs_rise | input | 1 | Chip select has risen (frame end) |
| cs_aligned | input | 1 | The frame end fell on a byte boundary |
| addr | input | ADDR_W | Array address targeted by the front end |
| status | output | 8 | Status byte |
| write_ok | output | 1 | Array write permitted at addr |

## Verification
The checker assumes that the front end sends at most one opcode strobe per frame, and that it sends the opcode strobe, the data-byte strobes and the chip-select rise in separate cycles. The bench's frame task drives exactly that sequence, with one strobe per cycle. The checker also assumes that addr is stable while a frame is in flight. The bench sets addr before each frame and changes it only between frames. For the random frames the bench waits out each program cycle before starting the next frame, so its reference model never has to track a countdown. Directed cases cover commands sent during a busy period and wp_n falling during one.

// File: rtl/psu_pkg.sv
package psu_pkg;

    localparam logic [7:0] OPC_SET_WE  = 8'h06;
    localparam logic [7:0] OPC_CLR_WE  = 8'h04;
    localparam logic [7:0] OPC_RD_STAT = 8'h05;
    localparam logic [7:0] OPC_WR_STAT = 8'h01;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_WREN,
        FR_WRDI,
        FR_WRSR,
        FR_WRITE,
        FR_PASSIVE
    } fr_state_t;

    typedef enum logic {
        ST_READY,
        ST_BUSY
    } cyc_state_t;

    function automatic fr_state_t decode_op(input logic [7:0] op);
        if (op == OPC_SET_WE)                           return FR_WREN;
        else if (op == OPC_CLR_WE)                      return FR_WRDI;
        else if (op == OPC_WR_STAT)                     return FR_WRSR;
        else if (op[7:4] == 4'h0 && op[2:0] == 3'b010)  return FR_WRITE;
        else                                            return FR_PASSIVE;
    endfunction

endpackage

// File: rtl/psu_frame.sv
module psu_frame
    import psu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [7:0] op_code,
    input  logic       byte_stb,
    input  logic       cs_rise,
    input  logic       cs_aligned,
    output logic       set_we,
    output logic       clr_we,
    output logic       wr_stat,
    output logic       wr_array
);

    fr_state_t state_q, state_d;
    logic      data_q, data_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            data_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        state_d = state_q;
        data_d  = data_q;
        if (cs_rise) begin
            state_d = FR_IDLE;
            data_d  = 1'b0;
        end else if (op_valid) begin
            state_d = decode_op(op_code);
            data_d  = 1'b0;
        end else if (byte_stb && state_q != FR_IDLE) begin
            data_d  = 1'b1;
        end
    end

    always_comb begin
        set_we   = 1'b0;
        clr_we   = 1'b0;
        wr_stat  = 1'b0;
        wr_array = 1'b0;
        if (cs_rise && cs_aligned) begin
            unique case (state_q)
                FR_WREN:    set_we   = !data_q;
                FR_WRDI:    clr_we   = !data_q;
                FR_WRSR:    wr_stat  = data_q;
                FR_WRITE:   wr_array = data_q;
                FR_IDLE,
                FR_PASSIVE: ;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/psu_guard.sv
module psu_guard (
    input  logic [1:0] code,
    input  logic [1:0] top_bits,
    output logic       guarded
);

    always_comb begin
        unique case (code)
            2'b00: guarded = 1'b0;
            2'b01: guarded = (top_bits == 2'b11);
            2'b10: guarded = top_bits[1];
            2'b11: guarded = 1'b1;
            default: guarded = 1'b1;
        endcase
    end

endmodule

// File: rtl/psu_cycle.sv
module psu_cycle
    import psu_pkg::*;
#(
    parameter int WR_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);

    cyc_state_t      st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_READY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_READY: if (start) begin
                st_d  = ST_BUSY;
                cnt_d = LOAD - 1'b1;
            end
            ST_BUSY: begin
                if (cnt_q == '0) st_d = ST_READY;
                else             cnt_d = cnt_q - 1'b1;
            end
            default: st_d = ST_READY;
        endcase
    end

    assign busy = (st_q == ST_BUSY);

endmodule

// File: rtl/prot_status_unit.sv
module prot_status_unit
    import psu_pkg::*;
#(
    parameter int         ADDR_W    = 9,
    parameter int         WR_CYCLES = 8,
    parameter logic [1:0] BP_INIT   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic              byte_stb,
    input  logic [7:0]        sr_wdata,
    input  logic              cs_rise,
    input  logic              cs_aligned,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        status,
    output logic              write_ok
);

    logic       set_we, clr_we, wr_stat, wr_array;
    logic       busy, guarded, we_q, we_rst_n;
    logic [1:0] bp_q;
    logic       stat_go, array_go;
    logic       unused_bits;

    assign unused_bits = ^{sr_wdata[7:4], sr_wdata[1:0], addr[ADDR_W-3:0]};

    psu_frame i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .byte_stb   (byte_stb),
        .cs_rise    (cs_rise),
        .cs_aligned (cs_aligned),
        .set_we     (set_we),
        .clr_we     (clr_we),
        .wr_stat    (wr_stat),
        .wr_array   (wr_array)
    );

    psu_guard i_guard (
        .code     (bp_q),
        .top_bits (addr[ADDR_W-1 -: 2]),
        .guarded  (guarded)
    );

    psu_cycle #(.WR_CYCLES(WR_CYCLES)) i_cycle (
        .clk   (clk),
        .rst_n (rst_n),
        .start (stat_go | array_go),
        .busy  (busy)
    );

    assign write_ok = we_q & wp_n & ~guarded;
    assign stat_go  = wr_stat  & we_q & wp_n & ~busy;
    assign array_go = wr_array & write_ok & ~busy;
    assign we_rst_n = rst_n & wp_n;

    always_ff @(posedge clk or negedge we_rst_n) begin
        if (!we_rst_n)                             we_q <= 1'b0;
        else if (!busy && set_we)                  we_q <= 1'b1;
        else if (clr_we && !busy)                  we_q <= 1'b0;
        else if (stat_go || array_go)              we_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bp_q <= BP_INIT;
        else if (stat_go) bp_q <= sr_wdata[3:2];
    end

    assign status = {4'b0000, bp_q, we_q, busy};

endmodule

// File: rtl/psu_checker.sv
module psu_checker #(
    parameter int WR_CYCLES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic       cs_rise,
    input logic [7:0] status,
    input logic       write_ok
);

    localparam int CW = $clog2(WR_CYCLES + 2);
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (status[0]) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:4] == 4'h0);

    a_r4_wp_holds_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |-> !status[1]);

    a_r8_permit_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        write_ok |-> (status[1] && wp_n));

    a_r2_latch_rise_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(cs_rise));

    a_r5_code_change_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[3:2]) |-> $rose(status[0]));

    a_r10_code_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status[0]) && status[0]) |-> $stable(status[3:2]));

    a_r9_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> (run_q < CW'(WR_CYCLES)));

endmodule

bind prot_status_unit psu_checker #(.WR_CYCLES(WR_CYCLES)) i_psu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .cs_rise  (cs_rise),
    .status   (status),
    .write_ok (write_ok)
);

// File: tb/test_prot_status_unit.sv
module test_prot_status_unit;

    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_n = 1'b1;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic       byte_stb = 1'b0;
    logic [7:0] sr_wdata = 8'h00;
    logic       cs_rise = 1'b0;
    logic       cs_aligned = 1'b0;
    logic [8:0] addr = 9'h000;
    logic [7:0] status;
    logic       write_ok;

    int total = 0;
    int bad = 0;

    logic       m_we = 1'b0;
    logic [1:0] m_bp = 2'b00;
    logic       m_busy = 1'b0;

    always #5 clk = ~clk;

    prot_status_unit #(.ADDR_W(9), .WR_CYCLES(W), .BP_INIT(2'b00)) i_prot_status_unit (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .op_valid(op_valid), .op_code(op_code),
        .byte_stb(byte_stb), .sr_wdata(sr_wdata), .cs_rise(cs_rise),
        .cs_aligned(cs_aligned), .addr(addr), .status(status), .write_ok(write_ok)
    );

    function automatic logic in_guard(input logic [1:0] bp, input logic [8:0] a);
        return (bp == 2'd3) || (bp == 2'd2 && a >= 9'd256) || (bp == 2'd1 && a >= 9'd384);
    endfunction

    function automatic logic [7:0] exp_status();
        return {4'b0000, m_bp, m_we, m_busy};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(status == exp_status(), req, status, exp_status());
        chk(write_ok == (m_we && wp_n && !in_guard(m_bp, addr)), {req, "/R8"},
            write_ok, m_we && wp_n && !in_guard(m_bp, addr));
    endtask

    task automatic frame(input logic [7:0] op, input int nx, input logic [7:0] sd, input logic al);
        @(negedge clk); op_valid = 1'b1; op_code = op;
        @(negedge clk); op_valid = 1'b0;
        for (int i = 0; i < nx; i++) begin
            byte_stb = 1'b1; sr_wdata = sd;
            @(negedge clk); byte_stb = 1'b0;
        end
        sr_wdata = sd; cs_rise = 1'b1; cs_aligned = al;
        @(negedge clk); cs_rise = 1'b0; cs_aligned = 1'b0;
    endtask

    // reference update at frame end
    task automatic model(input logic [7:0] op, input int nx, input logic [7:0] sd, input logic al);
        logic is_wr;
        is_wr = (op[7:4] == 4'h0) && (op[2:0] == 3'b010);
        if (!al || m_busy) return;
        if (op == 8'h06 && nx == 0)      m_we = wp_n;
        else if (op == 8'h04 && nx == 0) m_we = 1'b0;
        else if (op == 8'h01 && nx > 0 && m_we && wp_n) begin
            m_bp = sd[3:2]; m_we = 1'b0; m_busy = 1'b1;
        end else if (is_wr && nx > 0 && m_we && wp_n && !in_guard(m_bp, addr)) begin
            m_we = 1'b0; m_busy = 1'b1;
        end
    endtask

    task automatic run(input logic [7:0] op, input int nx, input logic [7:0] sd, input logic al,
                       input string req);
        frame(op, nx, sd, al);
        model(op, nx, sd, al);
        chk_all(req);
    endtask

    task automatic drain(input string req);
        if (m_busy) begin
            repeat (W) @(negedge clk);
            m_busy = 1'b0;
            chk_all(req);
        end
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset");

        // R2: set, then extra byte and misaligned end leave latch alone
        run(8'h04, 0, 8'h00, 1'b1, "R3 clear");
        run(8'h06, 2, 8'h00, 1'b1, "R2 extra byte");
        run(8'h06, 0, 8'h00, 1'b0, "R2 misaligned");
        run(8'h06, 0, 8'h00, 1'b1, "R2 set");
        run(8'h05, 1, 8'hFF, 1'b1, "R11 status read");
        run(8'h03, 2, 8'hFF, 1'b1, "R11 array read");

        // R4: asynchronous clear, set ignored while low
        @(negedge clk); wp_n = 1'b0; #1;
        m_we = 1'b0;
        chk(status[1] == 1'b0, "R4 async clear", status[1], 0);
        run(8'h06, 0, 8'h00, 1'b1, "R4 set while low");
        run(8'h01, 1, 8'h0C, 1'b1, "R4 status write blocked");
        @(negedge clk); wp_n = 1'b1;

        // R7/R8 boundaries for every code
        for (int c = 0; c < 4; c++) begin
            run(8'h06, 0, 8'h00, 1'b1, "R2 set");
            run(8'h01, 1, {4'hA, c[1:0], 2'b11}, 1'b1, "R5 code load");
            drain("R9 end");
            run(8'h06, 0, 8'h00, 1'b1, "R2 set");
            for (int k = 0; k < 6; k++) begin
                logic [8:0] a;
                case (k)
                    0: a = 9'h000; 1: a = 9'h0FF; 2: a = 9'h100;
                    3: a = 9'h17F; 4: a = 9'h180; default: a = 9'h1FF;
                endcase
                addr = a; #1;
                chk(write_ok == !in_guard(m_bp, a), "R7 range", write_ok, !in_guard(m_bp, a));
                @(negedge clk);
            end
        end
        run(8'h01, 1, 8'h00, 1'b1, "R5 code clear");
        drain("R9 end");

        // R9: wp_n low during a cycle does not shorten it
        run(8'h06, 0, 8'h00, 1'b1, "R2 set");
        addr = 9'h044;
        run(8'h0A, 1, 8'h55, 1'b1, "R6 accepted");
        wp_n = 1'b0;
        repeat (W - 1) @(negedge clk);
        chk(status[0] == 1'b1, "R9 still busy", status[0], 1);
        @(negedge clk);
        m_busy = 1'b0;
        chk(status[0] == 1'b0, "R9 done", status[0], 0);
        wp_n = 1'b1;

        // R10: commands while busy
        run(8'h06, 0, 8'h00, 1'b1, "R2 set");
        run(8'h02, 1, 8'h00, 1'b1, "R6 accepted");
        run(8'h06, 0, 8'h00, 1'b1, "R10 set while busy");
        run(8'h01, 1, 8'h0C, 1'b1, "R10 status write while busy");
        drain("R10 end");
        run(8'h02, 1, 8'h00, 1'b1, "R6 refused without latch");

        // random frames
        for (int it = 0; it < 400; it++) begin
            int pick, nx;
            logic [7:0] op;
            pick = $urandom_range(0, 6);
            case (pick)
                0: op = 8'h06; 1: op = 8'h04; 2: op = 8'h05; 3: op = 8'h01;
                4: op = 8'h02; 5: op = 8'h0A; default: op = 8'h03;
            endcase
            if (pick < 2 && $urandom_range(0, 3) != 0) nx = 0;
            else nx = $urandom_range(0, 2);
            @(negedge clk);
            wp_n = ($urandom_range(0, 9) != 0);
            if (!wp_n) m_we = 1'b0;
            addr = 9'($urandom);
            run(op, nx, 8'($urandom), ($urandom_range(0, 9) != 0), "R5/R6 random");
            drain("R9 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule